// File: doc/BRIEF.md
# Stereo Audio De-emphasis Filter

This block applies a selectable first-order shelving de-emphasis to a stereo stream of 18-bit two's-complement samples at the audio sample rate. Each sample pair comes with a one-cycle strobe. A 2-bit rate code chooses one of three fixed coefficient sets, for 32 kHz, 44.1 kHz or 48 kHz sampling, or a bypass. Each set inverts the standard 50 µs / 15 µs emphasis curve. The filtered pair leaves one clock later with its own strobe.

Both channels run the same recurrence, y[n] = b0·x[n] + b1·x[n−1] − a1·y[n−1], on separate state registers and share the coefficients. The recursive state carries 8 extra fractional bits. Every result is rounded and then clamped, so it never wraps. A new rate code takes effect on the next strobe, and that strobe starts from cleared state.

Top module: `deemph_filter`

## Requirements
- R1: While rst_ni is low, and after it is released until the first strobe, out_valid_o is 0 and both sample outputs are 0.
- R2: out_valid_o is high for exactly the one cycle after each cycle with in_valid_i high. The sample outputs change only in that cycle and hold their value otherwise.
- R3: Rate code 01 is bypass. The output equals the input sample bit for bit, with the same one-cycle latency as the filtered path.
- R4: Coefficients are integers scaled by 2^16 and given as (b0, b1, a1). Code 00 (44.1 kHz) uses (28141, −3913, −41308). Code 10 (48 kHz) uses (27570, −4971, −42937). Code 11 (32 kHz) uses (30583, 625, −34328).
- R5: Let X = x·256 and let S be the state in units of 2^−8. Then acc = b0·X[n] + b1·X[n−1] − a1·S[n−1], and S[n] = floor((acc + 2^15)/2^16), clamped to the range [−2^25, (2^17−1)·256]. The output is floor((S[n] + 128)/256), clamped to the range [−131072, 131071].
- R6: Saturation never wraps. A sustained input of +131071 or −131072 settles to exactly that same code.
- R7: A strobe whose rate code differs from the code of the previous strobe is computed with X[n−1] and S[n−1] taken as 0. After reset, the previous code counts as 01. A zero input on such a strobe therefore gives a zero output.
- R8: The left and right channels use the same coefficients and separate state. Activity on one channel never changes the other channel's output.
- R9: The DC gain is exactly one. Any constant input eventually produces exactly that input value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Sample-pair strobe |
| rate_sel_i | input | 2 | Rate code: 00 44.1 kHz, 01 bypass, 10 48 kHz, 11 32 kHz |
| left_i | input | 18 | Left input sample, two's complement |
| right_i | input | 18 | Right input sample, two's complement |
| out_valid_o | output | 1 | Output strobe, one cycle after in_valid_i |
| left_o | output | 18 | Left filtered sample |
| right_o | output | 18 | Right filtered sample |

## Verification
An impulse on the left channel alone is run under each rate code. The impulse responses separate the three coefficient sets, and the idle right channel exposes any crosstalk. A long constant input, a sustained full-scale level and an abrupt full-scale reversal show exact DC gain, rounding and clamping, and whether a result wraps. Runs that change the rate code in the middle of a stream show whether the state is cleared on that strobe. Bypass runs with extreme codes show whether data passes through untouched.

// File: rtl/deemph_pkg.sv
package deemph_pkg;
  parameter int DATA_W    = 18;
  parameter int FRAC_W    = 8;
  parameter int COEF_W    = 18;
  parameter int COEF_FRAC = 16;
  parameter int NUM_CH    = 2;

  localparam int SW    = DATA_W + FRAC_W;
  localparam int ACC_W = SW + COEF_W + 2;

  typedef enum logic [1:0] {
    RATE_44K1 = 2'b00,
    RATE_OFF  = 2'b01,
    RATE_48K  = 2'b10,
    RATE_32K  = 2'b11
  } rate_e;

  typedef struct packed {
    logic signed [COEF_W-1:0] b0;
    logic signed [COEF_W-1:0] b1;
    logic signed [COEF_W-1:0] a1;
  } coef_t;
endpackage

// File: rtl/deemph_coef_sel.sv
module deemph_coef_sel
  import deemph_pkg::*;
(
  input  logic [1:0] rate_i,
  output coef_t      coef_o,
  output logic       bypass_o
);
  // bilinear transform of (1+s*15us)/(1+s*50us), scaled by 2^COEF_FRAC,
  // b0+b1 == 2^COEF_FRAC + a1 so DC gain is exact
  always_comb begin
    coef_o   = '0;
    bypass_o = 1'b0;
    unique case (rate_e'(rate_i))
      RATE_44K1: begin
        coef_o.b0 = COEF_W'(28141);
        coef_o.b1 = -COEF_W'(3913);
        coef_o.a1 = -COEF_W'(41308);
      end
      RATE_48K: begin
        coef_o.b0 = COEF_W'(27570);
        coef_o.b1 = -COEF_W'(4971);
        coef_o.a1 = -COEF_W'(42937);
      end
      RATE_32K: begin
        coef_o.b0 = COEF_W'(30583);
        coef_o.b1 = COEF_W'(625);
        coef_o.a1 = -COEF_W'(34328);
      end
      default: bypass_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/deemph_channel.sv
module deemph_channel
  import deemph_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic                     clear_i,
  input  logic                     bypass_i,
  input  coef_t                    coef_i,
  input  logic signed [DATA_W-1:0] x_i,
  output logic signed [DATA_W-1:0] y_o
);
  localparam longint S_MAX_L = ((longint'(1) <<< (DATA_W-1)) - 1) <<< FRAC_W;
  localparam longint S_MIN_L = -(longint'(1) <<< (DATA_W-1+FRAC_W));
  localparam longint D_MAX_L = (longint'(1) <<< (DATA_W-1)) - 1;
  localparam longint D_MIN_L = -(longint'(1) <<< (DATA_W-1));
  localparam logic signed [ACC_W-1:0] S_MAX_A = ACC_W'(S_MAX_L);
  localparam logic signed [ACC_W-1:0] S_MIN_A = ACC_W'(S_MIN_L);
  localparam logic signed [ACC_W-1:0] ACC_HALF = ACC_W'(longint'(1) <<< (COEF_FRAC-1));
  localparam logic signed [SW:0]      O_HALF  = (SW+1)'(longint'(1) <<< (FRAC_W-1));
  localparam logic signed [SW:0]      D_MAX_O = (SW+1)'(D_MAX_L);
  localparam logic signed [SW:0]      D_MIN_O = (SW+1)'(D_MIN_L);

  logic signed [SW-1:0]     xp_q, s_q, xs, xp_use, s_use, s_new;
  logic signed [ACC_W-1:0]  acc, rnd;
  logic signed [SW:0]       o_sum, o_sh;
  logic signed [DATA_W-1:0] y_new, y_q;

  always_comb begin
    xs     = $signed({x_i, {FRAC_W{1'b0}}});
    xp_use = clear_i ? '0 : xp_q;
    s_use  = clear_i ? '0 : s_q;
    acc = ACC_W'($signed(coef_i.b0)) * ACC_W'(xs)
        + ACC_W'($signed(coef_i.b1)) * ACC_W'(xp_use)
        - ACC_W'($signed(coef_i.a1)) * ACC_W'(s_use);
    rnd = (acc + ACC_HALF) >>> COEF_FRAC;
    if (rnd > S_MAX_A)      s_new = SW'(S_MAX_L);
    else if (rnd < S_MIN_A) s_new = SW'(S_MIN_L);
    else                    s_new = rnd[SW-1:0];
    o_sum = (SW+1)'(s_new) + O_HALF;
    o_sh  = o_sum >>> FRAC_W;
    if (o_sh > D_MAX_O)      y_new = DATA_W'(D_MAX_L);
    else if (o_sh < D_MIN_O) y_new = DATA_W'(D_MIN_L);
    else                     y_new = o_sh[DATA_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xp_q <= '0;
      s_q  <= '0;
      y_q  <= '0;
    end else if (valid_i) begin
      if (bypass_i) begin
        xp_q <= '0;
        s_q  <= '0;
        y_q  <= x_i;
      end else begin
        xp_q <= xs;
        s_q  <= s_new;
        y_q  <= y_new;
      end
    end
  end

  assign y_o = y_q;

  // R7: cleared state plus zero input leaves nothing to output
  p_zero_after_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && clear_i && x_i == '0) |=> (y_o == '0));

  // R5: first filtered sample after a clear is b0*x, so it keeps x's sign or rounds to 0
  p_first_sign_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && clear_i && !bypass_i) |=> (y_o == '0 || y_o[DATA_W-1] == $past(x_i[DATA_W-1])));
endmodule

// File: rtl/deemph_filter.sv
module deemph_filter
  import deemph_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [1:0]        rate_sel_i,
  input  logic [DATA_W-1:0] left_i,
  input  logic [DATA_W-1:0] right_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] left_o,
  output logic [DATA_W-1:0] right_o
);
  coef_t                          coef;
  logic                           bypass;
  logic [1:0]                     rate_q;
  logic                           clear;
  logic                           valid_q;
  logic [NUM_CH-1:0][DATA_W-1:0]  x_ch, y_ch;

  deemph_coef_sel i_coef_sel (
    .rate_i   (rate_sel_i),
    .coef_o   (coef),
    .bypass_o (bypass)
  );

  assign clear = (rate_sel_i != rate_q);
  assign x_ch  = {right_i, left_i};

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      deemph_channel i_channel (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .valid_i  (in_valid_i),
        .clear_i  (clear),
        .bypass_i (bypass),
        .coef_i   (coef),
        .x_i      ($signed(x_ch[c])),
        .y_o      (y_ch[c])
      );
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q  <= RATE_OFF;
      valid_q <= 1'b0;
    end else begin
      valid_q <= in_valid_i;
      if (in_valid_i) rate_q <= rate_sel_i;
    end
  end

  assign out_valid_o = valid_q;
  assign left_o      = y_ch[0];
  assign right_o     = y_ch[NUM_CH-1];

  // R3: bypass is bit-exact with one cycle of latency
  p_bypass_exact_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && rate_sel_i == RATE_OFF) |=> (left_o == $past(left_i) && right_o == $past(right_i)));

  // R2: outputs move only on a strobe
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> ($stable(left_o) && $stable(right_o)));
endmodule

// File: tb/test_deemph_filter.sv
module test_deemph_filter;
  localparam int DW = 18;
  localparam longint DMAX = 131071;
  localparam longint DMIN = -131072;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          in_valid = 1'b0;
  logic [1:0]    rate_sel = 2'b01;
  logic [DW-1:0] left_in = '0, right_in = '0;
  logic          out_valid;
  logic [DW-1:0] left_out, right_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  longint m_xp[2];
  longint m_s[2];
  logic [1:0] m_last;

  always #5 clk = ~clk;

  deemph_filter i_deemph_filter (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid),
    .rate_sel_i  (rate_sel),
    .left_i      (left_in),
    .right_i     (right_in),
    .out_valid_o (out_valid),
    .left_o      (left_out),
    .right_o     (right_out)
  );

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint sx(logic [DW-1:0] v);
    return longint'($signed(v));
  endfunction

  function automatic longint clampl(longint v, longint lo, longint hi);
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  // R4 coefficient table, R5 recurrence, R7 clear rule
  function automatic longint model(int ch, longint x, logic [1:0] code);
    longint b0, b1, a1, xp, s, acc, sn, y;
    case (code)
      2'b00: begin b0 = 28141; b1 = -3913; a1 = -41308; end
      2'b10: begin b0 = 27570; b1 = -4971; a1 = -42937; end
      2'b11: begin b0 = 30583; b1 = 625;   a1 = -34328; end
      default: begin b0 = 0; b1 = 0; a1 = 0; end
    endcase
    if (code == 2'b01) begin
      m_xp[ch] = 0;
      m_s[ch]  = 0;
      return x;
    end
    xp = (code != m_last) ? 0 : m_xp[ch];
    s  = (code != m_last) ? 0 : m_s[ch];
    acc = b0 * (x * 256) + b1 * xp - a1 * s;
    sn  = clampl((acc + 32768) >>> 16, -(longint'(1) <<< 25), DMAX * 256);
    y   = clampl((sn + 128) >>> 8, DMIN, DMAX);
    m_xp[ch] = x * 256;
    m_s[ch]  = sn;
    return y;
  endfunction

  // one strobe, checked one cycle later against the model
  task automatic send(string req, logic [1:0] code, longint l, longint r, output longint el, output longint er);
    el = model(0, l, code);
    er = model(1, r, code);
    m_last = code;
    @(negedge clk);
    in_valid = 1'b1;
    rate_sel = code;
    left_in  = DW'(l);
    right_in = DW'(r);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_chk(string req, logic [1:0] code, longint l, longint r);
    longint el, er;
    send(req, code, l, r, el, er);
    check(req, sx(left_out), el);
    check(req, sx(right_out), er);
  endtask

  task automatic t_reset;
    check("R1 valid", longint'(out_valid), 0);
    check("R1 left", sx(left_out), 0);
    check("R1 right", sx(right_out), 0);
  endtask

  task automatic t_bypass;
    longint el, er;
    send("R3", 2'b01, DMAX, DMIN, el, er);
    check("R2 strobe", longint'(out_valid), 1);
    check("R3 left", sx(left_out), DMAX);
    check("R3 right", sx(right_out), DMIN);
    @(negedge clk);
    check("R2 strobe drop", longint'(out_valid), 0);
    send_chk("R3", 2'b01, -1, 77);
    send_chk("R3", 2'b01, 0, -5);
  endtask

  task automatic t_impulse(logic [1:0] code);
    send_chk("R4 R5 impulse", code, 65536, 0);
    for (int i = 0; i < 6; i++) begin
      send_chk("R4 R5 tail", code, 0, 0);
      check("R8 right idle", sx(right_out), 0);
    end
  endtask

  task automatic t_dc;
    longint el, er;
    for (int i = 0; i < 300; i++) begin
      send("R9", 2'b00, 12345, -999, el, er);
      check("R5 dc step", sx(left_out), el);
      check("R5 dc step", sx(right_out), er);
    end
    check("R9 dc left", sx(left_out), 12345);
    check("R9 dc right", sx(right_out), -999);
  endtask

  task automatic t_fullscale;
    longint el, er;
    for (int i = 0; i < 300; i++) begin
      send("R6", 2'b10, DMAX, DMIN, el, er);
      check("R6 step", sx(left_out), el);
    end
    check("R6 pos fs", sx(left_out), DMAX);
    check("R6 neg fs", sx(right_out), DMIN);
    send_chk("R6 reversal", 2'b10, DMIN, DMAX);
    send_chk("R6 reversal", 2'b10, DMIN, DMAX);
  endtask

  task automatic t_rate_change;
    for (int i = 0; i < 5; i++) send_chk("R7 prime", 2'b11, 90000, -70000);
    send_chk("R7 switch", 2'b00, 0, 0);
    check("R7 zero left", sx(left_out), 0);
    check("R7 zero right", sx(right_out), 0);
    send_chk("R7 after", 2'b00, 4000, -4000);
    send_chk("R7 switch 48", 2'b10, 1234, 4321);
  endtask

  task automatic t_hold;
    longint l0, r0;
    send_chk("R2 hold", 2'b11, 5555, -6666);
    l0 = sx(left_out);
    r0 = sx(right_out);
    left_in  = DW'(longint'(100));
    right_in = DW'(longint'(-100));
    rate_sel = 2'b00;
    repeat (5) @(negedge clk);
    check("R2 hold valid", longint'(out_valid), 0);
    check("R2 hold left", sx(left_out), l0);
    check("R2 hold right", sx(right_out), r0);
  endtask

  initial begin
    m_xp = '{0, 0};
    m_s  = '{0, 0};
    m_last = 2'b01;
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_bypass();
    t_impulse(2'b00);
    t_impulse(2'b10);
    t_impulse(2'b11);
    t_dc();
    t_fullscale();
    t_rate_change();
    t_hold();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule